// File: doc/BRIEF.md
# ECC-Protected SRAM Controller with Read-Modify-Write

This controller connects a simple single-outstanding bus slave port to a synchronous single-port SRAM that stores 39 bits per word. Each word holds 32 data bits and a 7-bit single-error-correct, double-error-detect check field. Reads return corrected data. Single-bit faults in any of the 39 stored bits are repaired on the way out. Words whose faults cannot be repaired are answered with an error.

Writes use one of two paths. An aligned word write with all four byte strobes set is encoded and stored in one cycle, with no RAM read. Every other write goes through a read, check, merge, re-encode and write sequence, so the stored check field always matches its data. That includes byte and halfword writes, word writes with partial strobes, and any write whose address is not a multiple of its size. If that sequence reads a word it cannot correct, the write is dropped and the bus gets an error. Single-cycle status pulses report corrected and uncorrectable events.

Top module: `ecc_sram_ctrl`

## Requirements
- R1: An aligned word write (`bus_size`=2'b10, address bits [1:0]=0, `bus_strb`=4'hF) performs one RAM write and no RAM read, and `bus_ready` stays high in the cycle after acceptance.
- R2: The stored word places the 32 data bits in bits [38:7] and the 7 check bits in bits [6:0].
- R3: A read accepted at a clock edge returns its data with `bus_ready` high in the following cycle. A second read may be accepted in that same cycle, so back-to-back reads complete one per cycle.
- R4: Any write other than the R1 case sets `bus_ready` low for exactly 3 cycles after acceptance. It performs one RAM read, then one RAM write, and changes only the selected byte lanes (lane n is bits [8n+7:8n] of `bus_wdata`).
- R5: The selected lanes are the transfer's size window, with the address rounded down to the size boundary (byte: lane addr[1:0]; halfword: lanes 0-1 or 2-3 by addr[1]; word: all four lanes), ANDed with `bus_strb`.
- R6: A write whose address is not a multiple of its size always takes the R4 path, even when all strobes are set.
- R7: A read of a word with one flipped bit, in any of the 39 positions, returns the original data with `bus_err` low. It raises `evt_corr` for one cycle, one cycle after the data cycle, and `evt_corr` and `evt_uncorr` are never high together. The stored word is not rewritten, so a second read reports the correction again.
- R8: A read of a word with two flipped bits, including a never-written word, returns `bus_err` high in the data cycle and raises `evt_uncorr` one cycle later.
- R9: If the read inside a read-modify-write is uncorrectable, no RAM write occurs, `bus_err` is high when `bus_ready` returns, and `evt_uncorr` pulses.
- R10: If the read inside a read-modify-write holds a single-bit error, the corrected word is merged and written back, `evt_corr` pulses, and a later read of that word reports no event.
- R11: Out of reset `bus_ready` is high, and `ram_en`, `bus_err`, `evt_corr` and `evt_uncorr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Transfer request, accepted when `bus_ready` is high |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_size | input | 2 | 00 byte, 01 halfword, 1x word |
| bus_strb | input | 4 | Byte-lane strobes for writes |
| bus_wdata | input | 32 | Write data on its byte lanes |
| bus_ready | output | 1 | High when a transfer may be accepted; marks read data and response |
| bus_rdata | output | 32 | Corrected read data, valid in the read data cycle |
| bus_err | output | 1 | Error response with `bus_ready` |
| evt_corr | output | 1 | One-cycle pulse on a corrected single-bit error |
| evt_uncorr | output | 1 | One-cycle pulse on an uncorrectable error |
| ram_en | output | 1 | RAM access enable |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | ADDR_W-2 | RAM word address |
| ram_wdata | output | 39 | Codeword to RAM |
| ram_rdata | input | 39 | Codeword from RAM, one cycle after a read |

## Verification
Writes are tried as aligned full words, single bytes and halfwords at every offset, word writes with sparse strobes, and unaligned word writes with full strobes. Comparing stall counts and RAM read/write counts for these cases separates the direct path from the read-modify-write path, and the read-back data shows that lane selection and rounding are correct. Single bits are flipped in the RAM model at data, check and parity positions, then read twice, which shows both correction and the absence of scrubbing. Double flips and never-written words, on plain reads and on partial writes, separate the error response from the aborted write. A constrained-random mix of all of these runs against a shadow copy of the data.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
  localparam int DATA_W   = 32;
  localparam int HAM_W    = 6;
  localparam int CHK_W    = HAM_W + 1;
  localparam int CW_W     = DATA_W + CHK_W;
  localparam int LANES    = DATA_W / 8;
  localparam int LAST_POS = DATA_W + HAM_W;

  // Hamming position (1-based) of data bit idx: non-powers of two in order.
  function automatic int data_pos(input int idx);
    int n;
    int res;
    n   = 0;
    res = 0;
    for (int c = 1; c <= LAST_POS; c++) begin
      if ((c & (c - 1)) != 0) begin
        if (n == idx) res = c;
        n++;
      end
    end
    return res;
  endfunction

  // Data bits covered by Hamming check bit k.
  function automatic logic [DATA_W-1:0] cover_mask(input int k);
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (((data_pos(i) >> k) & 1) != 0) m[i] = 1'b1;
    end
    return m;
  endfunction

  // Byte lanes inside the transfer window after rounding the address down.
  function automatic logic [LANES-1:0] lane_window(input logic [1:0] off,
                                                   input logic [1:0] size);
    logic [LANES-1:0] w;
    case (size)
      2'b00:   w = LANES'(1) << off;
      2'b01:   w = off[1] ? 4'b1100 : 4'b0011;
      default: w = '1;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
  import ecc_sram_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  logic [HAM_W-1:0] ham;

  for (genvar k = 0; k < HAM_W; k++) begin : g_ham
    localparam logic [DATA_W-1:0] COVER = cover_mask(k);
    assign ham[k] = ^(data & COVER);
  end

  // Top check bit makes the whole 39-bit word even parity.
  assign chk = {^{data, ham}, ham};
endmodule

// File: rtl/secded_dec.sv
module secded_dec
  import ecc_sram_pkg::*;
(
  input  logic [CW_W-1:0]   cw,
  output logic [DATA_W-1:0] data_out,
  output logic              single_err,
  output logic              double_err
);
  logic [DATA_W-1:0] raw;
  logic [CHK_W-1:0]  chk;
  logic [HAM_W-1:0]  syn;
  logic              odd;
  logic              in_range;

  assign raw = cw[CW_W-1:CHK_W];
  assign chk = cw[CHK_W-1:0];

  for (genvar k = 0; k < HAM_W; k++) begin : g_syn
    localparam logic [DATA_W-1:0] COVER = cover_mask(k);
    assign syn[k] = chk[k] ^ (^(raw & COVER));
  end

  assign odd      = ^cw;
  assign in_range = (syn <= HAM_W'(LAST_POS));

  // Odd parity with a syndrome inside the word: one flipped bit.
  // Even parity with a nonzero syndrome, or a syndrome past the word: not repairable.
  assign single_err = odd && in_range;
  assign double_err = (!odd && (syn != '0)) || (odd && !in_range);

  for (genvar g = 0; g < DATA_W; g++) begin : g_fix
    localparam logic [HAM_W-1:0] POS = HAM_W'(data_pos(g));
    assign data_out[g] = raw[g] ^ (single_err && (syn == POS));
  end
endmodule

// File: rtl/lane_merge.sv
module lane_merge
  import ecc_sram_pkg::*;
(
  input  logic [DATA_W-1:0] old_data,
  input  logic [DATA_W-1:0] new_data,
  input  logic [LANES-1:0]  lanes,
  output logic [DATA_W-1:0] merged
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged[8*l +: 8] = lanes[l] ? new_data[8*l +: 8] : old_data[8*l +: 8];
  end
endmodule

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
  import ecc_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [1:0]          bus_size,
  input  logic [LANES-1:0]    bus_strb,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic                bus_ready,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                bus_err,
  output logic                evt_corr,
  output logic                evt_uncorr,
  output logic                ram_en,
  output logic                ram_we,
  output logic [ADDR_W-3:0]   ram_addr,
  output logic [CW_W-1:0]     ram_wdata,
  input  logic [CW_W-1:0]     ram_rdata
);
  localparam int WADDR_W = ADDR_W - 2;

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RMW_RD, S_RMW_CHK, S_RMW_WR, S_RESP
  } state_e;

  state_e             st;
  logic               rdy;
  logic               acc;
  logic               is_full;
  logic               acc_read;
  logic               acc_full;
  logic               acc_rmw;
  logic               dec_phase;
  logic [WADDR_W-1:0] bus_word;
  logic [LANES-1:0]   bus_lanes;

  logic [WADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  wdata_q;
  logic [LANES-1:0]   lanes_q;
  logic [DATA_W-1:0]  old_q;
  logic               abort_q;
  logic [CW_W-1:0]    cw_q;

  logic [DATA_W-1:0]  dec_data;
  logic               dec_single;
  logic               dec_double;
  logic [DATA_W-1:0]  merged;
  logic [DATA_W-1:0]  enc_in;
  logic [CHK_W-1:0]   enc_chk;

  // Request decode
  assign rdy       = (st == S_IDLE) || (st == S_RD) || (st == S_RESP);
  assign acc       = bus_sel && rdy;
  assign bus_word  = bus_addr[ADDR_W-1:2];
  assign bus_lanes = lane_window(bus_addr[1:0], bus_size) & bus_strb;
  assign is_full   = bus_size[1] && (bus_addr[1:0] == 2'b00) && (&bus_strb);
  assign acc_read  = acc && !bus_write;
  assign acc_full  = acc && bus_write && is_full;
  assign acc_rmw   = acc && bus_write && !is_full;
  assign dec_phase = (st == S_RD) || (st == S_RMW_RD);

  secded_dec u_dec (
    .cw         (ram_rdata),
    .data_out   (dec_data),
    .single_err (dec_single),
    .double_err (dec_double)
  );

  lane_merge u_merge (
    .old_data (old_q),
    .new_data (wdata_q),
    .lanes    (lanes_q),
    .merged   (merged)
  );

  // One encoder shared by the direct write and the merge stage.
  assign enc_in = (st == S_RMW_CHK) ? merged : bus_wdata;

  secded_enc u_enc (
    .data (enc_in),
    .chk  (enc_chk)
  );

  // Sequencer and status registers
  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      addr_q     <= '0;
      wdata_q    <= '0;
      lanes_q    <= '0;
      old_q      <= '0;
      abort_q    <= 1'b0;
      cw_q       <= '0;
      evt_corr   <= 1'b0;
      evt_uncorr <= 1'b0;
    end else begin
      evt_corr   <= dec_phase && dec_single;
      evt_uncorr <= dec_phase && dec_double;
      case (st)
        S_RMW_RD: begin
          old_q   <= dec_data;
          abort_q <= dec_double;
          st      <= S_RMW_CHK;
        end
        S_RMW_CHK: begin
          cw_q <= {merged, enc_chk};
          st   <= S_RMW_WR;
        end
        S_RMW_WR: st <= S_RESP;
        default: begin
          if (acc_read) begin
            st <= S_RD;
          end else if (acc_rmw) begin
            st      <= S_RMW_RD;
            addr_q  <= bus_word;
            wdata_q <= bus_wdata;
            lanes_q <= bus_lanes;
          end else begin
            st <= S_IDLE;
          end
        end
      endcase
    end
  end

  // RAM port: the write-back owns it in S_RMW_WR, otherwise a new request drives it.
  always_comb begin
    ram_en    = 1'b0;
    ram_we    = 1'b0;
    ram_addr  = bus_word;
    ram_wdata = {bus_wdata, enc_chk};
    if (st == S_RMW_WR) begin
      ram_en    = !abort_q;
      ram_we    = !abort_q;
      ram_addr  = addr_q;
      ram_wdata = cw_q;
    end else if (acc) begin
      ram_en = 1'b1;
      ram_we = acc_full;
    end
  end

  // Bus response
  assign bus_ready = rdy;
  assign bus_rdata = (st == S_RD) ? dec_data : '0;
  assign bus_err   = ((st == S_RD) && dec_double) || ((st == S_RESP) && abort_q);

  // Assertions
  p_full_no_stall_r1: assert property (@(posedge clk) disable iff (rst)
    acc_full |=> bus_ready);

  p_read_next_r3: assert property (@(posedge clk) disable iff (rst)
    acc_read |=> bus_ready);

  p_rmw_stall_r4: assert property (@(posedge clk) disable iff (rst)
    acc_rmw |=> !bus_ready ##1 !bus_ready ##1 !bus_ready ##1 bus_ready);

  p_rmw_reads_first_r4: assert property (@(posedge clk) disable iff (rst)
    acc_rmw |-> (ram_en && !ram_we));

  p_unaligned_rmw_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && bus_write && (bus_addr[1:0] != 2'b00)) |-> !ram_we);

  p_evt_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({evt_corr, evt_uncorr}));

  p_abort_no_write_r9: assert property (@(posedge clk) disable iff (rst)
    ((st == S_RMW_WR) && abort_q) |-> !ram_en);

  p_abort_err_r9: assert property (@(posedge clk) disable iff (rst)
    ((st == S_RMW_WR) && abort_q) |=> (bus_ready && bus_err));
endmodule

// File: tb/tb_ecc_sram_ctrl.sv
module tb_ecc_sram_ctrl;
  localparam int ADDR_W = 10;
  localparam int WADDR_W = ADDR_W - 2;
  localparam int DEPTH = 1 << WADDR_W;

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;

  logic               bus_sel, bus_write;
  logic [ADDR_W-1:0]  bus_addr;
  logic [1:0]         bus_size;
  logic [3:0]         bus_strb;
  logic [31:0]        bus_wdata;
  logic               bus_ready, bus_err, evt_corr, evt_uncorr;
  logic [31:0]        bus_rdata;
  logic               ram_en, ram_we;
  logic [WADDR_W-1:0] ram_addr;
  logic [38:0]        ram_wdata, ram_rdata;

  ecc_sram_ctrl #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_strb(bus_strb),
    .bus_wdata(bus_wdata), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .evt_corr(evt_corr), .evt_uncorr(evt_uncorr),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // SRAM model with fault injection; reset fills it with a double-error pattern.
  logic [38:0]        mem [DEPTH];
  int unsigned        n_ram_rd, n_ram_wr;
  logic [38:0]        last_wcw;
  logic               inj_en;
  logic [WADDR_W-1:0] inj_addr;
  logic [38:0]        inj_mask;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 39'h3;
      n_ram_rd  <= 0;
      n_ram_wr  <= 0;
      ram_rdata <= '0;
      last_wcw  <= '0;
    end else begin
      if (inj_en) mem[inj_addr] <= mem[inj_addr] ^ inj_mask;
      if (ram_en) begin
        if (ram_we) begin
          mem[ram_addr] <= ram_wdata;
          last_wcw      <= ram_wdata;
          n_ram_wr      <= n_ram_wr + 1;
        end else begin
          ram_rdata <= mem[ram_addr];
          n_ram_rd  <= n_ram_rd + 1;
        end
      end
    end
  end

  // Expected state
  logic [31:0] shadow [DEPTH];
  bit          poisoned [DEPTH];
  bit          sbe [DEPTH];
  int checks = 0;
  int fails = 0;
  int seed_sink;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_lanes(input logic [1:0] off, input logic [1:0] sz,
                                           input logic [3:0] strb);
    logic [3:0] w;
    if (sz == 2'b00)      w = 4'b0001 << off;
    else if (sz == 2'b01) w = (off >= 2) ? 4'b1100 : 4'b0011;
    else                  w = 4'b1111;
    return w & strb;
  endfunction

  task automatic idle_bus();
    bus_sel = 1'b0; bus_write = 1'b0; bus_addr = '0;
    bus_size = 2'b00; bus_strb = 4'h0; bus_wdata = '0;
  endtask

  task automatic rd_check(input int w, input string req);
    logic [31:0] d;
    logic e, rdy, ec, eu;
    bus_sel = 1'b1; bus_write = 1'b0; bus_addr = ADDR_W'(w * 4); bus_size = 2'b10;
    @(posedge clk); @(negedge clk);
    rdy = bus_ready; d = bus_rdata; e = bus_err;
    idle_bus();
    @(posedge clk); @(negedge clk);
    ec = evt_corr; eu = evt_uncorr;
    check(rdy == 1'b1, "R3", "read ready in data cycle", 64'(rdy), 64'd1);
    if (poisoned[w]) begin
      check(e == 1'b1, req, "read err on uncorrectable", 64'(e), 64'd1);
      check(eu == 1'b1, req, "evt_uncorr after read", 64'(eu), 64'd1);
    end else begin
      check(d == shadow[w], req, "read data", 64'(d), 64'(shadow[w]));
      check(e == 1'b0, req, "read err", 64'(e), 64'd0);
      check(ec == sbe[w], req, "evt_corr after read", 64'(ec), 64'(sbe[w]));
      check(eu == 1'b0, req, "evt_uncorr after read", 64'(eu), 64'd0);
    end
  endtask

  task automatic wr_check(input int w, input logic [1:0] off, input logic [1:0] sz,
                          input logic [3:0] strb, input logic [31:0] data,
                          input string req);
    int unsigned rd0, wr0;
    int stalls;
    logic e, ec, eu;
    logic [3:0] ln;
    bit full;
    full = (sz[1] == 1'b1) && (off == 2'b00) && (strb == 4'hF);
    ln = exp_lanes(off, sz, strb);
    rd0 = n_ram_rd; wr0 = n_ram_wr;
    bus_sel = 1'b1; bus_write = 1'b1; bus_addr = ADDR_W'(w * 4 + int'(off));
    bus_size = sz; bus_strb = strb; bus_wdata = data;
    @(posedge clk); @(negedge clk);
    idle_bus();
    stalls = 0; ec = 1'b0; eu = 1'b0;
    while (!bus_ready && stalls < 10) begin
      ec |= evt_corr; eu |= evt_uncorr;
      stalls++;
      @(posedge clk); @(negedge clk);
    end
    e = bus_err; ec |= evt_corr; eu |= evt_uncorr;
    @(posedge clk); @(negedge clk);
    ec |= evt_corr; eu |= evt_uncorr;
    if (full) begin
      check(stalls == 0, req, "direct write stalls", 64'(stalls), 64'd0);
      check((n_ram_rd - rd0) == 0, req, "direct write RAM reads", 64'(n_ram_rd - rd0), 64'd0);
      check((n_ram_wr - wr0) == 1, req, "direct write RAM writes", 64'(n_ram_wr - wr0), 64'd1);
      check(last_wcw[38:7] == data, "R2", "data field of stored word", 64'(last_wcw[38:7]), 64'(data));
      check(e == 1'b0, req, "direct write err", 64'(e), 64'd0);
      shadow[w] = data; poisoned[w] = 1'b0; sbe[w] = 1'b0;
    end else begin
      check(stalls == 3, req, "rmw stall cycles", 64'(stalls), 64'd3);
      check((n_ram_rd - rd0) == 1, req, "rmw RAM reads", 64'(n_ram_rd - rd0), 64'd1);
      if (poisoned[w]) begin
        check((n_ram_wr - wr0) == 0, "R9", "aborted rmw RAM writes", 64'(n_ram_wr - wr0), 64'd0);
        check(e == 1'b1, "R9", "aborted rmw err", 64'(e), 64'd1);
        check(eu == 1'b1, "R9", "aborted rmw evt_uncorr", 64'(eu), 64'd1);
      end else begin
        check((n_ram_wr - wr0) == 1, req, "rmw RAM writes", 64'(n_ram_wr - wr0), 64'd1);
        check(e == 1'b0, req, "rmw err", 64'(e), 64'd0);
        check(ec == sbe[w], "R10", "rmw evt_corr", 64'(ec), 64'(sbe[w]));
        for (int l = 0; l < 4; l++)
          if (ln[l]) shadow[w][8*l +: 8] = data[8*l +: 8];
        sbe[w] = 1'b0;
      end
    end
  endtask

  task automatic inject(input int w, input logic [38:0] mask);
    inj_en = 1'b1; inj_addr = WADDR_W'(w); inj_mask = mask;
    @(posedge clk); @(negedge clk);
    inj_en = 1'b0;
    if ($countones(mask) == 1) sbe[w] = 1'b1;
    else begin poisoned[w] = 1'b1; sbe[w] = 1'b0; end
  endtask

  task automatic b2b_reads(input int a0, input int a1);
    bus_sel = 1'b1; bus_write = 1'b0; bus_size = 2'b10; bus_addr = ADDR_W'(a0 * 4);
    @(posedge clk); @(negedge clk);
    check(bus_ready == 1'b1, "R3", "first beat ready", 64'(bus_ready), 64'd1);
    check(bus_rdata == shadow[a0], "R3", "first beat data", 64'(bus_rdata), 64'(shadow[a0]));
    bus_addr = ADDR_W'(a1 * 4);
    @(posedge clk); @(negedge clk);
    check(bus_ready == 1'b1, "R3", "second beat ready", 64'(bus_ready), 64'd1);
    check(bus_rdata == shadow[a1], "R3", "second beat data", 64'(bus_rdata), 64'(shadow[a1]));
    idle_bus();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    seed_sink = $urandom(32'h5eed);
    idle_bus();
    inj_en = 1'b0; inj_addr = '0; inj_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin shadow[i] = '0; poisoned[i] = 1'b1; sbe[i] = 1'b0; end
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(posedge clk); @(negedge clk);
    // R11 reset state
    check(bus_ready == 1'b1, "R11", "ready after reset", 64'(bus_ready), 64'd1);
    check(ram_en == 1'b0, "R11", "ram_en after reset", 64'(ram_en), 64'd0);
    check({bus_err, evt_corr, evt_uncorr} == 3'b000, "R11", "status after reset",
          64'({bus_err, evt_corr, evt_uncorr}), 64'd0);

    for (int w = 0; w < 16; w++) wr_check(w, 2'd0, 2'b10, 4'hF, $urandom, "R1");
    for (int w = 0; w < 16; w++) rd_check(w, "R1");

    rd_check(100, "R8");                                   // never written
    wr_check(101, 2'd1, 2'b00, 4'hF, 32'h1234_5678, "R9"); // rmw on unwritten word
    rd_check(101, "R9");

    wr_check(2, 2'd1, 2'b00, 4'hF, 32'hA5A5_A5A5, "R4");   // byte lane 1
    rd_check(2, "R4");
    wr_check(3, 2'd3, 2'b01, 4'hF, 32'hDEAD_BEEF, "R5");   // half at offset 3 -> lanes 2,3
    rd_check(3, "R5");
    wr_check(6, 2'd0, 2'b10, 4'b0101, 32'h1122_3344, "R5"); // sparse strobes
    rd_check(6, "R5");
    wr_check(4, 2'd2, 2'b10, 4'hF, 32'hCAFE_F00D, "R6");   // unaligned word
    rd_check(4, "R6");
    wr_check(5, 2'd1, 2'b01, 4'hF, 32'h0BAD_0BAD, "R6");   // unaligned half

    b2b_reads(7, 8);

    // R7: single flips at check, parity and data positions, no scrub
    for (int k = 0; k < 5; k++) begin
      int b;
      b = (k == 0) ? 0 : (k == 1) ? 6 : (k == 2) ? 7 : (k == 3) ? 38 : 20;
      inject(11, 39'(1) << b);
      rd_check(11, "R7");
      rd_check(11, "R7");
      wr_check(11, 2'd0, 2'b10, 4'hF, shadow[11], "R1");
    end

    inject(9, 39'(1) << 25);
    wr_check(9, 2'd0, 2'b00, 4'h1, 32'h0000_00EE, "R10");
    rd_check(9, "R10");

    inject(10, (39'(1) << 9) | (39'(1) << 30));
    rd_check(10, "R8");
    wr_check(10, 2'd0, 2'b01, 4'h3, 32'h0000_5555, "R9");
    rd_check(10, "R9");
    wr_check(10, 2'd0, 2'b10, 4'hF, 32'h7777_1111, "R1");
    rd_check(10, "R8");

    for (int n = 0; n < 400; n++) begin
      int op, w;
      op = int'($urandom % 8);
      w  = int'($urandom % 16);
      case (op)
        0, 1, 2: rd_check(w, "R3");
        3, 4:    wr_check(w, 2'($urandom), 2'($urandom), 4'($urandom), $urandom, "R4");
        5:       wr_check(w, 2'd0, 2'b10, 4'hF, $urandom, "R1");
        6: begin
          inject(w, 39'(1) << ($urandom % 39));
          rd_check(w, "R7");
          wr_check(w, 2'd0, 2'b10, 4'hF, shadow[w], "R1");
        end
        default: wr_check(w, 2'(1 + $urandom % 3), 2'b10, 4'hF, $urandom, "R6");
      endcase
    end

    finish_run();
  end
endmodule